// File: doc/BRIEF.md
# Light Sensor I2C Register Interface

This block is the two-wire serial target of an ambient light sensor. A host reaches eight byte-wide registers through it: a command byte and a control byte that configure the converter, two interrupt threshold bytes, and four read-only bytes that expose the latest 16-bit sensor result and the 16-bit timer count. SCL and SDA are sampled by the system clock through synchronizers; SDA is driven open-drain, so the block only ever pulls the line low.

A write is the device address with the write bit, a register-address byte, then a single data byte. A read sets the register pointer the same way, then issues a repeated START with the read bit and takes one byte, ending with a not-acknowledge and STOP. The two top bits of the register-address byte are action strobes rather than address bits: bit 7 requests an integration sync and bit 6 requests an interrupt clear, each as a one-cycle pulse to the sequencer and interrupt logic. The slave address is 0b10001 followed by two strap pins. The block has no stream data path; all configuration and strobe pins are plain levels or pulses with no back-pressure.

Top module: `lux_i2c_regs`

## Requirements
- R1: The block acknowledges only the 7-bit address {5'b10001, addr_strap[1], addr_strap[0]} (0x44 to 0x47); for any other address it never asserts sda_pull until the next START.
- R2: A write of device address, register byte and data byte has every byte acknowledged and stores the data byte in the register selected by bits 2:0 of the register byte; a second data byte in the same transaction is not acknowledged and not stored.
- R3: A read (pointer write, repeated START, address with read bit) returns the selected register MSB first, with the block releasing SDA during the host's acknowledge bit.
- R4: Register-byte bit 7 = 1 produces exactly one clk-cycle pulse on sync_pulse; bit 6 = 1 produces exactly one pulse on int_clear_pulse and clears int_flag; neither bit changes the register index taken from bits 2:0.
- R5: Register 0x00 holds conv_enable in bit 7, power_down in bit 6, ext_timing in bit 5, diode_mode in bits 3:2 and conv_width in bits 1:0; bit 4 always reads 0.
- R6: Register 0x01 holds int_flag in bit 5, gain_range in bits 3:2 and persist_sel in bits 1:0, with bits 7, 6 and 4 reading 0; a one-cycle int_event sets int_flag, writing 0 to bit 5 clears it, writing 1 to bit 5 leaves it unchanged.
- R7: After reset registers 0x00 and 0x01 read 0x00 (converter disabled), thresh_hi (0x02) reads 0xFF and thresh_lo (0x03) reads 0x00.
- R8: Registers 0x04 to 0x07 are read-only: writes to them are acknowledged but change no register or output; 0x04 and 0x06 return the low bytes of sensor_value and timer_value.
- R9: Reading 0x04 (or 0x06) captures the high byte of sensor_value (or timer_value) at that moment; a later read of 0x05 (or 0x07) returns the captured byte even if the input has since changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_strap | input | 2 | Strap pins forming the two address LSBs |
| sensor_value | input | 16 | Latest sensor conversion result |
| timer_value | input | 16 | Timer count for the latest conversion |
| int_event | input | 1 | One-cycle request to set the interrupt flag |
| conv_enable | output | 1 | Converter enable |
| power_down | output | 1 | Power-down request |
| ext_timing | output | 1 | 1 selects host-timed integration |
| diode_mode | output | 2 | Photodiode selection mode |
| conv_width | output | 2 | Integration cycle count select |
| gain_range | output | 2 | Full-scale range select |
| persist_sel | output | 2 | Interrupt persistence select |
| thresh_hi | output | 8 | Upper threshold high byte |
| thresh_lo | output | 8 | Lower threshold high byte |
| int_flag | output | 1 | Interrupt flag |
| sync_pulse | output | 1 | One-cycle integration sync strobe |
| int_clear_pulse | output | 1 | One-cycle interrupt clear strobe |

## Verification
A bit counter or state that slips by one shows at the very next acknowledge slot, where SDA is either not pulled or pulled a bit early, so the host's ACK sample for that byte reads wrong within nine SCL periods. A corrupted register pointer or field mapping shows on the first read-back as a byte with bits in the wrong places, and directly on the configuration pins within a few system clocks of the STOP-free data acknowledge. Strobe decode faults appear as a missing, doubled or misdirected pulse counted during the register-byte acknowledge, and a broken snapshot shows as a high byte that tracks the live input instead of the value captured at the low-byte read.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_WDAT, ST_READ, ST_SKIP
  } tgt_state_e;

  localparam logic [2:0] REG_CMD    = 3'd0;
  localparam logic [2:0] REG_CTL    = 3'd1;
  localparam logic [2:0] REG_THI    = 3'd2;
  localparam logic [2:0] REG_TLO    = 3'd3;
  localparam logic [2:0] REG_SNS_LO = 3'd4;
  localparam logic [2:0] REG_SNS_HI = 3'd5;
  localparam logic [2:0] REG_TMR_LO = 3'd6;
  localparam logic [2:0] REG_TMR_HI = 3'd7;
endpackage

// File: rtl/lux_i2c_sync.sv
module lux_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
      sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/lux_i2c_target.sv
module lux_i2c_target
  import lux_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b10001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] strap,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [2:0] reg_ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       rd_take,
  output logic       sync_pulse,
  output logic       clr_pulse
);
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;

  tgt_state_e state;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       is_read;
  logic       active;

  assign active = (state != ST_IDLE) && (state != ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; shreg <= '0; bitcnt <= '0; is_read <= 1'b0;
      sda_oe <= 1'b0; reg_ptr <= '0; wr_en <= 1'b0; wr_data <= '0;
      rd_take <= 1'b0; sync_pulse <= 1'b0; clr_pulse <= 1'b0;
    end else begin
      wr_en <= 1'b0; rd_take <= 1'b0; sync_pulse <= 1'b0; clr_pulse <= 1'b0;
      if (start_det) begin
        state <= ST_DEV; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else if (active && scl_rise) begin
        if (bitcnt != BIT_ACK) bitcnt <= bitcnt + 4'd1;
        if (state != ST_READ && bitcnt < BIT_LAST) shreg <= {shreg[6:0], sda_lvl};
      end else if (active && scl_fall) begin
        if (bitcnt == BIT_LAST) begin
          unique case (state)
            ST_DEV:
              if (shreg[7:1] == {ADDR_HI, strap}) begin
                sda_oe <= 1'b1; is_read <= shreg[0];
              end else state <= ST_SKIP;
            ST_REG: begin
              sda_oe <= 1'b1; reg_ptr <= shreg[2:0];
              sync_pulse <= shreg[7]; clr_pulse <= shreg[6];
            end
            ST_WDAT: begin
              sda_oe <= 1'b1; wr_en <= 1'b1; wr_data <= shreg;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == BIT_ACK) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          unique case (state)
            ST_DEV:
              if (is_read) begin
                state <= ST_READ; rd_take <= 1'b1;
                sda_oe <= ~rd_data[7]; shreg <= {rd_data[6:0], 1'b0};
              end else state <= ST_REG;
            ST_REG:  state <= ST_WDAT;
            default: state <= ST_SKIP;
          endcase
        end else if (state == ST_READ && bitcnt != 4'd0) begin
          sda_oe <= ~shreg[7];
          shreg  <= {shreg[6:0], 1'b0};
        end
      end
    end
  end

  // R4
  sync_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
  // R4
  clr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  // R1
  skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);
  // R3
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

// File: rtl/lux_reg_bank.sv
module lux_reg_bank
  import lux_i2c_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] THI_RESET = 8'hFF,
  parameter logic [BYTE_W-1:0] TLO_RESET = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          ptr,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_take,
  input  logic                clr_pulse,
  input  logic                int_event,
  input  logic [2*BYTE_W-1:0] sensor_value,
  input  logic [2*BYTE_W-1:0] timer_value,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [BYTE_W-1:0]   cmd_q,
  output logic [3:0]          ctl_q,
  output logic                int_flag,
  output logic [BYTE_W-1:0]   thresh_hi,
  output logic [BYTE_W-1:0]   thresh_lo
);
  localparam int VAL_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] CMD_MASK = 8'hEF;

  logic [BYTE_W-1:0] sns_hold, tmr_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; ctl_q <= '0; int_flag <= 1'b0;
      thresh_hi <= THI_RESET; thresh_lo <= TLO_RESET;
      sns_hold <= '0; tmr_hold <= '0;
    end else begin
      if (wr_en) begin
        unique case (ptr)
          REG_CMD: cmd_q <= wr_data & CMD_MASK;
          REG_CTL: ctl_q <= wr_data[3:0];
          REG_THI: thresh_hi <= wr_data;
          REG_TLO: thresh_lo <= wr_data;
          default: ;
        endcase
      end
      if (int_event) int_flag <= 1'b1;
      else if (clr_pulse || (wr_en && ptr == REG_CTL && !wr_data[5])) int_flag <= 1'b0;
      if (rd_take && ptr == REG_SNS_LO) sns_hold <= sensor_value[VAL_W-1:BYTE_W];
      if (rd_take && ptr == REG_TMR_LO) tmr_hold <= timer_value[VAL_W-1:BYTE_W];
    end
  end

  always_comb begin
    unique case (ptr)
      REG_CMD:    rd_data = cmd_q;
      REG_CTL:    rd_data = {2'b00, int_flag, 1'b0, ctl_q};
      REG_THI:    rd_data = thresh_hi;
      REG_TLO:    rd_data = thresh_lo;
      REG_SNS_LO: rd_data = sensor_value[BYTE_W-1:0];
      REG_SNS_HI: rd_data = sns_hold;
      REG_TMR_LO: rd_data = timer_value[BYTE_W-1:0];
      default:    rd_data = tmr_hold;
    endcase
  end

  // R2
  thi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == REG_THI) |=> thresh_hi == $past(wr_data));
  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr[2]) |=> ($stable(thresh_hi) && $stable(thresh_lo) && $stable(cmd_q) && $stable(ctl_q)));
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_event |=> int_flag);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !int_event) |=> !int_flag);
endmodule

// File: rtl/lux_i2c_regs.sv
module lux_i2c_regs #(
  parameter int SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI = 5'b10001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  input  logic [1:0]  addr_strap,
  input  logic [15:0] sensor_value,
  input  logic [15:0] timer_value,
  input  logic        int_event,
  output logic        conv_enable,
  output logic        power_down,
  output logic        ext_timing,
  output logic [1:0]  diode_mode,
  output logic [1:0]  conv_width,
  output logic [1:0]  gain_range,
  output logic [1:0]  persist_sel,
  output logic [7:0]  thresh_hi,
  output logic [7:0]  thresh_lo,
  output logic        int_flag,
  output logic        sync_pulse,
  output logic        int_clear_pulse
);
  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [2:0] reg_ptr;
  logic       wr_en, rd_take;
  logic [7:0] wr_data, rd_data, cmd_q;
  logic [3:0] ctl_q;

  lux_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  lux_i2c_target #(.ADDR_HI(ADDR_HI)) u_tgt (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap), .rd_data(rd_data), .sda_oe(sda_pull),
    .reg_ptr(reg_ptr), .wr_en(wr_en), .wr_data(wr_data), .rd_take(rd_take),
    .sync_pulse(sync_pulse), .clr_pulse(int_clear_pulse));

  lux_reg_bank #(.BYTE_W(8)) u_bank (
    .clk(clk), .rst_n(rst_n), .ptr(reg_ptr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_take(rd_take), .clr_pulse(int_clear_pulse), .int_event(int_event),
    .sensor_value(sensor_value), .timer_value(timer_value), .rd_data(rd_data),
    .cmd_q(cmd_q), .ctl_q(ctl_q), .int_flag(int_flag),
    .thresh_hi(thresh_hi), .thresh_lo(thresh_lo));

  assign conv_enable = cmd_q[7];
  assign power_down  = cmd_q[6];
  assign ext_timing  = cmd_q[5];
  assign diode_mode  = cmd_q[3:2];
  assign conv_width  = cmd_q[1:0];
  assign gain_range  = ctl_q[3:2];
  assign persist_sel = ctl_q[1:0];
endmodule

// File: tb/lux_i2c_regs_test.sv
`timescale 1ns/1ps
module lux_i2c_regs_test;
  localparam int QC = 10;
  localparam logic [6:0] DEV = 7'h46;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [1:0] addr_strap = 2'b10;
  logic [15:0] sensor_value = 16'h1234, timer_value = 16'h5678;
  logic int_event = 1'b0;
  logic conv_enable, power_down, ext_timing, int_flag, sync_pulse, int_clear_pulse;
  logic [1:0] diode_mode, conv_width, gain_range, persist_sel;
  logic [7:0] thresh_hi, thresh_lo;
  wire sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0, sync_cnt = 0, clr_cnt = 0, pull_cnt = 0;

  always #2 clk = ~clk;

  lux_i2c_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
    .addr_strap(addr_strap), .sensor_value(sensor_value), .timer_value(timer_value),
    .int_event(int_event), .conv_enable(conv_enable), .power_down(power_down),
    .ext_timing(ext_timing), .diode_mode(diode_mode), .conv_width(conv_width),
    .gain_range(gain_range), .persist_sel(persist_sel), .thresh_hi(thresh_hi),
    .thresh_lo(thresh_lo), .int_flag(int_flag), .sync_pulse(sync_pulse),
    .int_clear_pulse(int_clear_pulse));

  always @(posedge clk) begin
    if (sync_pulse) sync_cnt++;
    if (int_clear_pulse) clr_cnt++;
    if (sda_pull) pull_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QC) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1'b1; q(); d = {d[6:0], sda_bus}; q(); scl_m = 1'b0;
    end
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic reg_write(input logic [7:0] rb, input logic [7:0] data, input string req);
    logic a0, a1, a2;
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(rb, a1); send_byte(data, a2); i2c_stop();
    chk({req, " write acks"}, {a0, a1, a2}, 3'b111);
  endtask

  task automatic reg_read(input logic [7:0] rb, output logic [7:0] d, input string req);
    logic a0, a1, a2;
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(rb, a1);
    i2c_start(); send_byte({DEV, 1'b1}, a2); recv_byte(d); i2c_stop();
    chk({req, " read acks"}, {a0, a1, a2}, 3'b111);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 reset outputs", {conv_enable, power_down, ext_timing, diode_mode, conv_width,
        gain_range, persist_sel, int_flag, sda_pull}, '0);
    chk("R7 reset thresholds", {thresh_hi, thresh_lo}, 16'hFF00);
    reg_read(8'h02, d, "R7"); chk("R7 thi read", d, 8'hFF);
    reg_read(8'h03, d, "R7"); chk("R7 tlo read", d, 8'h00);
    reg_read(8'h00, d, "R7"); chk("R7 cmd read", d, 8'h00);
    reg_read(8'h01, d, "R7"); chk("R7 ctl read", d, 8'h00);
  endtask

  task automatic t_address();
    logic a;
    pull_cnt = 0;
    i2c_start(); send_byte({7'h44, 1'b0}, a); send_byte(8'h02, a); i2c_stop();
    chk("R1 foreign address nack", a, 1'b0);
    chk("R1 foreign address never pulls", pull_cnt, 0);
    i2c_start(); send_byte({DEV, 1'b0}, a); i2c_stop();
    chk("R1 own address ack", a, 1'b1);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    reg_write(8'h00, 8'hFF, "R5"); reg_read(8'h00, d, "R5");
    chk("R5 reserved bit4 reads 0", d, 8'hEF);
    reg_write(8'h00, 8'hA6, "R5"); reg_read(8'h00, d, "R5");
    chk("R5 cmd readback", d, 8'hA6);
    chk("R5 cmd fields", {conv_enable, power_down, ext_timing, diode_mode, conv_width},
        {1'b1, 1'b0, 1'b1, 2'd1, 2'd2});
  endtask

  task automatic t_ctl();
    logic [7:0] d;
    reg_write(8'h01, 8'hFF, "R6"); reg_read(8'h01, d, "R6");
    chk("R6 ctl masked readback", d, 8'h0F);
    chk("R6 ctl fields", {gain_range, persist_sel, int_flag}, {2'd3, 2'd3, 1'b0});
    @(negedge clk); int_event = 1'b1; @(negedge clk); int_event = 1'b0;
    chk("R6 int_event sets flag", int_flag, 1'b1);
    reg_write(8'h01, 8'h2D, "R6"); reg_read(8'h01, d, "R6");
    chk("R6 writing 1 keeps flag", d, 8'h2D);
    reg_write(8'h01, 8'h0D, "R6"); reg_read(8'h01, d, "R6");
    chk("R6 writing 0 clears flag", d, 8'h0D);
    chk("R6 flag pin cleared", int_flag, 1'b0);
  endtask

  task automatic t_strobes();
    logic a0, a1;
    logic [7:0] d;
    int s0, c0;
    s0 = sync_cnt; c0 = clr_cnt;
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h80, a1); i2c_stop();
    chk("R4 sync strobe single pulse", sync_cnt - s0, 1);
    chk("R4 sync strobe no clear", clr_cnt - c0, 0);
    @(negedge clk); int_event = 1'b1; @(negedge clk); int_event = 1'b0;
    s0 = sync_cnt; c0 = clr_cnt;
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h41, a1); i2c_stop();
    chk("R4 clear strobe single pulse", clr_cnt - c0, 1);
    chk("R4 clear strobe no sync", sync_cnt - s0, 0);
    chk("R4 clear strobe drops flag", int_flag, 1'b0);
    reg_write(8'h03, 8'h3C, "R4");
    s0 = sync_cnt; c0 = clr_cnt;
    reg_read(8'hC3, d, "R4");
    chk("R4 strobe bits keep index", d, 8'h3C);
    chk("R4 both strobes once", {sync_cnt - s0, clr_cnt - c0}, {32'd1, 32'd1});
  endtask

  task automatic t_thresholds();
    logic a0, a1, a2, a3;
    logic [7:0] d;
    reg_write(8'h02, 8'h5A, "R2"); reg_write(8'h03, 8'hA5, "R2");
    chk("R2 threshold pins", {thresh_hi, thresh_lo}, 16'h5AA5);
    reg_read(8'h02, d, "R3"); chk("R3 read thi MSB first", d, 8'h5A);
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h02, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3); i2c_stop();
    chk("R2 second data byte nacked", {a0, a1, a2, a3}, 4'b1110);
    chk("R2 second data byte not stored", thresh_hi, 8'h11);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    reg_write(8'h04, 8'hEE, "R8"); reg_write(8'h07, 8'h00, "R8");
    chk("R8 ro write leaves thresholds", {thresh_hi, thresh_lo}, 16'h11A5);
    reg_read(8'h00, d, "R8"); chk("R8 ro write leaves cmd", d, 8'hA6);
    reg_read(8'h04, d, "R8"); chk("R8 sensor low byte", d, 8'h34);
    reg_read(8'h06, d, "R8"); chk("R8 timer low byte", d, 8'h78);
  endtask

  task automatic t_snapshot();
    logic [7:0] d;
    sensor_value = 16'h1234; timer_value = 16'h5678;
    reg_read(8'h04, d, "R9"); chk("R9 sensor lo", d, 8'h34);
    sensor_value = 16'hABCD;
    reg_read(8'h05, d, "R9"); chk("R9 sensor hi is snapshot", d, 8'h12);
    reg_read(8'h04, d, "R9"); chk("R9 sensor lo new", d, 8'hCD);
    reg_read(8'h05, d, "R9"); chk("R9 sensor hi new", d, 8'hAB);
    reg_read(8'h06, d, "R9");
    timer_value = 16'h9999;
    reg_read(8'h07, d, "R9"); chk("R9 timer hi is snapshot", d, 8'h56);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_address();
    t_cmd();
    t_ctl();
    t_strobes();
    t_thresholds();
    t_readonly();
    t_snapshot();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule